// File: doc/BRIEF.md
# One-Wire ROM Search Triplet Step

This block carries out a single step of the one-wire bus ROM search. After a start strobe it asks a bit-timing engine for two read slots. Each read slot is a touch-1 slot: the line is released, and the engine reports the level it samples. The first read gives the ID bit of the devices still taking part. The second gives its complement. From these two bits the block chooses a branch direction and asks for one write slot that drives that direction back onto the bus. Devices whose ID bit differs from the direction then leave the search.

When the devices disagree, both read bits are 0. The block then follows a preferred direction, which is latched at the start strobe. When both read bits are 1, no device answered. The block stops after the two reads and reports an error code. Each step ends with a one-cycle completion pulse and a 3-bit status. The status carries the ID bit, the complement bit and the direction taken. The caller keeps the discrepancy bookkeeping across the 64 search steps.

The engine interface is a level request with a one-cycle completion. The block holds `slot_req_o` high together with the slot kind and the write bit. The engine answers with a one-cycle `slot_done_i`. For read slots, the engine presents the sampled level on `slot_rbit_i` in that same cycle.

Top module: `rom_search_step`

## Requirements
- R1: After reset, `busy_o`, `slot_req_o` and `done_o` are 0 and `result_o` is 3'b000.
- R2: A start strobe seen while idle makes `busy_o` and `slot_req_o` high from the next cycle. The first two slots requested are reads (`slot_wr_o` = 0). The request, `slot_wr_o` and `slot_bit_o` hold steady until the cycle in which `slot_done_i` is high.
- R3: If both read bits are 1, the step ends after exactly two slot transactions with result 3'b011, and no write slot is requested.
- R4: If both read bits are 0, the direction is the preferred bit. The result is 3'b100 for preferred 1 and 3'b000 for preferred 0. A write slot with `slot_bit_o` equal to the preferred bit follows.
- R5: If exactly one read bit is 1, the direction equals the ID bit. The result is 3'b101 when the ID bit is 1 and 3'b010 when it is 0. A write slot carrying the ID bit follows.
- R6: Result field layout: bit 0 is the ID bit, bit 1 is the complement bit and bit 2 is the direction. Only 000, 100, 010, 101 and 011 ever appear with `done_o`.
- R7: `done_o` is high for exactly one cycle, the cycle after the final slot's `slot_done_i`. A non-error step takes exactly three slot transactions. `result_o` keeps its value until the next `done_o`.
- R8: A start strobe while `busy_o` is high is ignored. It adds no slot and does not change the step's result.
- R9: The preferred direction is sampled only at the accepted start strobe. Later changes of `pref_dir_i` do not affect the step.
- R10: During read slots `slot_bit_o` is 1 (touch-1). During the write slot `slot_wr_o` is 1 and `slot_bit_o` is the chosen direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for one step |
| pref_dir_i | input | 1 | Direction to take when the devices disagree |
| slot_req_o | output | 1 | Slot request to the bit-timing engine |
| slot_wr_o | output | 1 | Slot kind: 0 read (touch-1), 1 write |
| slot_bit_o | output | 1 | Level to write; 1 for read slots |
| slot_done_i | input | 1 | One-cycle completion of the requested slot |
| slot_rbit_i | input | 1 | Sampled bus level, valid with `slot_done_i` on read slots |
| busy_o | output | 1 | A step is in progress |
| done_o | output | 1 | One-cycle completion of the step |
| result_o | output | 3 | Status: {direction, complement bit, ID bit} |

## Verification
The assertions check on every cycle that:
- the completion pulse lasts one cycle;
- a request holds its kind and bit until it is answered;
- read slots drive 1;
- only the five legal status codes are ever reported;
- an error step consumed exactly two slot transactions and any other step exactly three, with the last of them being a read or a write respectively.

The tagging of the chosen direction in the write slot, the latching of the preferred direction, and the ignoring of a start strobe in the middle of a step depend on stimulus history. These are shown by the bench's scenarios against its reference model. The scenarios cover all four read-bit combinations under both preferred directions and several engine latencies.

// File: rtl/search_step_pkg.sv
package search_step_pkg;

  localparam int RES_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_ID  = 2'd1,
    ST_RD_CMP = 2'd2,
    ST_WR_DIR = 2'd3
  } step_state_t;

  localparam logic [RES_W-1:0] RES_ERROR = 3'b011;

  // status = {direction, complement, id}
  function automatic logic [RES_W-1:0] resolve_step(input logic id_bit,
                                                     input logic cmp_bit,
                                                     input logic pref);
    logic dir;
    if (id_bit && cmp_bit) begin
      return RES_ERROR;
    end
    dir = (!id_bit && !cmp_bit) ? pref : id_bit;
    return {dir, cmp_bit, id_bit};
  endfunction

endpackage

// File: rtl/search_step_decide.sv
module search_step_decide
  import search_step_pkg::*;
(
  input  logic             id_i,
  input  logic             cmp_i,
  input  logic             pref_i,
  output logic [RES_W-1:0] res_o,
  output logic             dir_o,
  output logic             err_o
);

  always_comb begin
    res_o = resolve_step(id_i, cmp_i, pref_i);
    err_o = (res_o == RES_ERROR);
    dir_o = res_o[RES_W-1];
  end

endmodule

// File: rtl/search_slot_port.sv
module search_slot_port
  import search_step_pkg::*;
(
  input  step_state_t state_i,
  input  logic        dir_i,
  input  logic        done_i,
  output logic        req_o,
  output logic        wr_o,
  output logic        bit_o,
  output logic        fire_o
);

  always_comb begin
    req_o  = (state_i != ST_IDLE);
    wr_o   = (state_i == ST_WR_DIR);
    bit_o  = wr_o ? dir_i : 1'b1;
    fire_o = req_o & done_i;
  end

endmodule

// File: rtl/search_step_seq.sv
module search_step_seq
  import search_step_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pref_i,
  input  logic             fire_i,
  input  logic             rbit_i,
  input  logic [RES_W-1:0] dec_res_i,
  input  logic             dec_err_i,
  output step_state_t      state_o,
  output logic             id_o,
  output logic             pref_o,
  output logic             dir_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             accept_o
);

  step_state_t      state_q;
  logic [RES_W-1:0] pend_q;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign state_o  = state_q;
  assign dir_o    = pend_q[RES_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      id_o     <= 1'b0;
      pref_o   <= 1'b0;
      pend_q   <= '0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            pref_o  <= pref_i;
            state_q <= ST_RD_ID;
          end
        end
        ST_RD_ID: begin
          if (fire_i) begin
            id_o    <= rbit_i;
            state_q <= ST_RD_CMP;
          end
        end
        ST_RD_CMP: begin
          if (fire_i) begin
            if (dec_err_i) begin
              result_o <= dec_res_i;
              done_o   <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              pend_q  <= dec_res_i;
              state_q <= ST_WR_DIR;
            end
          end
        end
        ST_WR_DIR: begin
          if (fire_i) begin
            result_o <= pend_q;
            done_o   <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rom_search_step.sv
module rom_search_step
  import search_step_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pref_dir_i,
  output logic             slot_req_o,
  output logic             slot_wr_o,
  output logic             slot_bit_o,
  input  logic             slot_done_i,
  input  logic             slot_rbit_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);

  step_state_t      state;
  logic             id_q;
  logic             pref_q;
  logic             dir_q;
  logic             slot_fire;
  logic             step_accept;
  logic [RES_W-1:0] dec_res;
  logic             dec_dir;
  logic             dec_err;

  search_step_decide u_decide (
    .id_i   (id_q),
    .cmp_i  (slot_rbit_i),
    .pref_i (pref_q),
    .res_o  (dec_res),
    .dir_o  (dec_dir),
    .err_o  (dec_err)
  );

  search_step_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .pref_i    (pref_dir_i),
    .fire_i    (slot_fire),
    .rbit_i    (slot_rbit_i),
    .dec_res_i ({dec_dir, dec_res[RES_W-2:0]}),
    .dec_err_i (dec_err),
    .state_o   (state),
    .id_o      (id_q),
    .pref_o    (pref_q),
    .dir_o     (dir_q),
    .done_o    (done_o),
    .result_o  (result_o),
    .accept_o  (step_accept)
  );

  search_slot_port u_port (
    .state_i (state),
    .dir_i   (dir_q),
    .done_i  (slot_done_i),
    .req_o   (slot_req_o),
    .wr_o    (slot_wr_o),
    .bit_o   (slot_bit_o),
    .fire_o  (slot_fire)
  );

  assign busy_o = slot_req_o;

endmodule

// File: rtl/rom_search_step_chk.sv
module rom_search_step_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       slot_req_o,
  input logic       slot_wr_o,
  input logic       slot_bit_o,
  input logic       slot_done_i,
  input logic       done_o,
  input logic [2:0] result_o,
  input logic       slot_fire,
  input logic       step_accept
);

  logic [1:0] fire_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           fire_cnt <= 2'd0;
    else if (step_accept) fire_cnt <= 2'd0;
    else if (slot_fire)   fire_cnt <= fire_cnt + 2'd1;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_accept |=> (slot_req_o && !slot_wr_o));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && !slot_done_i) |=>
      (slot_req_o && $stable(slot_wr_o) && $stable(slot_bit_o)));

  // R10
  read_touch_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req_o && !slot_wr_o) |-> slot_bit_o);

  // R6
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o == 3'b000 || result_o == 3'b100 ||
                result_o == 3'b010 || result_o == 3'b101 ||
                result_o == 3'b011));

  // R3
  error_two_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == 3'b011) |-> (fire_cnt == 2'd2 && !$past(slot_wr_o)));

  // R7
  normal_three_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o != 3'b011) |-> (fire_cnt == 2'd3 && $past(slot_wr_o)));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !slot_fire) |=> busy_o);

endmodule

bind rom_search_step rom_search_step_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .slot_req_o  (slot_req_o),
  .slot_wr_o   (slot_wr_o),
  .slot_bit_o  (slot_bit_o),
  .slot_done_i (slot_done_i),
  .done_o      (done_o),
  .result_o    (result_o),
  .slot_fire   (slot_fire),
  .step_accept (step_accept)
);

// File: tb/rom_search_step_bench.sv
module rom_search_step_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       pref_dir_i = 1'b0;
  logic       slot_done_i = 1'b0;
  logic       slot_rbit_i = 1'b0;
  logic       slot_req_o, slot_wr_o, slot_bit_o, busy_o, done_o;
  logic [2:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rom_search_step u_rom_search_step (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pref_dir_i(pref_dir_i),
    .slot_req_o(slot_req_o), .slot_wr_o(slot_wr_o), .slot_bit_o(slot_bit_o),
    .slot_done_i(slot_done_i), .slot_rbit_i(slot_rbit_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  // expected status from the requirement table (R3, R4, R5, R6)
  function automatic logic [2:0] expect_code(input bit id, input bit cmp, input bit pref);
    case ({id, cmp})
      2'b11:   return 3'b011;
      2'b00:   return pref ? 3'b100 : 3'b000;
      2'b10:   return 3'b101;
      default: return 3'b010;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit       m_busy = 0;
  int       m_slot = 0;
  bit       m_id = 0, m_cmp = 0, m_pref = 0, m_done = 0;
  logic [2:0] m_res = 3'b000;
  int       m_fires = 0;

  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      m_busy = 0; m_slot = 0; m_res = 3'b000; m_fires = 0;
    end else if (!m_busy) begin
      if (start_i) begin
        m_busy = 1; m_slot = 0; m_pref = pref_dir_i; m_fires = 0;
      end
    end else if (slot_done_i) begin
      m_fires++;
      if (m_slot == 0) begin
        m_id = slot_rbit_i; m_slot = 1;
      end else if (m_slot == 1) begin
        m_cmp = slot_rbit_i;
        if (m_id && m_cmp) begin
          m_res = 3'b011; m_done = 1; m_busy = 0;
        end else m_slot = 2;
      end else begin
        m_res = expect_code(m_id, m_cmp, m_pref); m_done = 1; m_busy = 0;
      end
    end
  end

  function automatic bit model_dir();
    if (!m_id && !m_cmp) return m_pref;
    return m_id;
  endfunction

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 busy", busy_o, m_busy);
      check("R2 slot_req", slot_req_o, m_busy);
      if (m_busy) begin
        check("R10 slot_wr", slot_wr_o, (m_slot == 2));
        check("R10 slot_bit", slot_bit_o, (m_slot == 2) ? model_dir() : 1'b1);
      end
      check("R7 done", done_o, m_done);
      check("R6 result", result_o, m_res);
    end
  end

  task automatic do_slot(input bit rb, input int lat);
    repeat (lat) @(negedge clk);
    check("R2 request present before answer", slot_req_o, 1);
    slot_done_i = 1'b1;
    slot_rbit_i = rb;
    @(negedge clk);
    slot_done_i = 1'b0;
    slot_rbit_i = 1'b0;
  endtask

  task automatic run_step(input bit id, input bit cmp, input bit pref,
                          input int lat, input bit disturb);
    logic [2:0] exp;
    exp = expect_code(id, cmp, pref);
    @(negedge clk);
    start_i = 1'b1;
    pref_dir_i = pref;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) pref_dir_i = ~pref;      // R9
    do_slot(id, lat);
    if (disturb) start_i = 1'b1;          // R8
    do_slot(cmp, lat);
    start_i = 1'b0;
    if (!(id && cmp)) begin
      check("R10 write slot kind", slot_wr_o, 1);
      check("R10 write slot bit", slot_bit_o, exp[2]);
      do_slot(1'b0, lat);
    end
    check("R7 done after final slot", done_o, 1);
    if (id && cmp) begin
      check("R3 error code", result_o, 3'b011);
      check("R3 two slots", m_fires, 2);
    end else if (!id && !cmp) begin
      check("R4 preferred direction code", result_o, exp);
      check("R4 three slots", m_fires, 3);
    end else begin
      check("R5 single-answer code", result_o, exp);
      check("R5 three slots", m_fires, 3);
    end
    if (disturb) check("R9 R8 result unaffected", result_o, exp);
    @(negedge clk);
    check("R7 result held", result_o, exp);
    check("R7 done one cycle", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy after reset", busy_o, 0);
    check("R1 req after reset", slot_req_o, 0);
    check("R1 done after reset", done_o, 0);
    check("R1 result after reset", result_o, 0);
    rst_n = 1'b1;
    for (int lat = 0; lat < 3; lat++)
      for (int p = 0; p < 2; p++)
        for (int c = 0; c < 4; c++)
          run_step(c[1], c[0], p[0], lat, 1'b0);
    for (int c = 0; c < 4; c++) run_step(c[1], c[0], 1'b1, 1, 1'b1);
    for (int c = 0; c < 4; c++) run_step(c[1], c[0], 1'b0, 2, 1'b1);
    repeat (4) @(negedge clk);
    check("R8 idle after runs", busy_o, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule